// File: doc/BRIEF.md
# Shared-Memory Multicycle Datapath

This block is the datapath of a 32-bit load/store processor that spends several clock cycles on each instruction. A single memory array holds both the program and its data. An address multiplexer chooses whether the program counter or the latched ALU result reaches that memory. Enabled and free-running internal registers carry the instruction, the memory data, the two register operands and the ALU result from one step to the next.

An external sequencer drives a set of select and enable inputs on every cycle. The datapath returns the opcode and function fields of the held instruction and a zero flag from the ALU. The sequencer uses these to choose its next step. The program counter, the memory address, the memory read and write data and the ALU result are also brought out so that the surrounding logic can observe them.

Top module: `shared_mem_datapath`

## Requirements
- R1: While `rst_n` is low and at its release, `pc` is 0, and the instruction register is 0, so `opcode` and `funct` read 0. The 32 registers also clear to 0.
- R2: `mem_addr` equals `pc` when `addr_sel_data`=0 and equals the latched ALU result when `addr_sel_data`=1. Memory is 64 words, indexed by address bits 7:2, and `mem_rdata` is a combinational read of that word.
- R3: The instruction register loads `mem_rdata` only on a clock where `ir_load`=1, and otherwise holds its value. `opcode` is instruction bits 31:26 and `funct` is bits 5:0. The data register captures `mem_rdata` on every clock.
- R4: On every clock, operand register A captures the register named by instruction bits 25:21, and operand register B captures the register named by bits 20:16. Register 0 always reads as 0, even after a write to it.
- R5: The register file writes on a clock where `rf_we`=1. The destination is instruction bits 20:16 when `wr_sel_rd`=0 and bits 15:11 when `wr_sel_rd`=1. The data written is the latched ALU result when `wb_sel_mem`=0 and the data register when `wb_sel_mem`=1.
- R6: ALU operand A is `pc` when `opa_sel_reg`=0 and operand register A when `opa_sel_reg`=1.
- R7: ALU operand B depends on `opb_sel`: 00 gives operand register B, 01 gives the constant 4, 10 gives bits 15:0 sign-extended, and 11 gives that sign-extended value shifted left by two.
- R8: `alu_op` selects the ALU function: 010 add, 110 subtract, 000 AND, 001 OR, 111 signed set-less-than (result 1 or 0). `zero_flag` is 1 exactly when `alu_y` is 0. The ALU result is latched on every clock.
- R9: `pc` loads on a clock where `pc_load`=1, or where `br_en`=1 and `zero_flag`=1. Otherwise it holds. The loaded value is `alu_y` when `pc_sel_reg`=0 and the latched ALU result when `pc_sel_reg`=1.
- R10: On a clock where `mem_we`=1, the word at `mem_addr` takes `mem_wdata`, which is operand register B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel_data | input | 1 | Memory address from the latched ALU result (1) or from the PC (0) |
| ir_load | input | 1 | Load the instruction register |
| pc_load | input | 1 | Unconditional PC load |
| br_en | input | 1 | PC load when the zero flag is set |
| pc_sel_reg | input | 1 | Next PC from the latched ALU result (1) or from the ALU (0) |
| opa_sel_reg | input | 1 | ALU operand A from register A (1) or from the PC (0) |
| opb_sel | input | 2 | ALU operand B select |
| alu_op | input | 3 | ALU function |
| wr_sel_rd | input | 1 | Destination register from bits 15:11 (1) or from bits 20:16 (0) |
| wb_sel_mem | input | 1 | Write-back data from the data register (1) or from the ALU result (0) |
| rf_we | input | 1 | Register file write enable |
| mem_we | input | 1 | Memory write enable |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero_flag | output | 1 | ALU result is zero |
| pc | output | 32 | Program counter |
| mem_addr | output | 32 | Memory address |
| mem_rdata | output | 32 | Memory read data |
| mem_wdata | output | 32 | Memory write data |
| alu_y | output | 32 | Combinational ALU result |

## Verification
The properties assume that the select and enable inputs are stable across each rising edge and take only defined values. They also assume that a branch step sets `pc_sel_reg` to the latched ALU result. The bench changes every control input shortly after a rising edge. It issues only the fetch, decode, address, memory, execute, write-back and branch steps, each with legal field values. It preloads a short program and its data into the memory before reset is released, and executes loads, a store, ALU operations, a write to register 0 and a branch in both its taken and not-taken forms.

// File: rtl/shared_mem_datapath.sv
module shared_mem_datapath #(
  parameter int XLEN       = 32,
  parameter int MEM_WORDS  = 64,
  parameter int NREGS      = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            addr_sel_data,
  input  logic            ir_load,
  input  logic            pc_load,
  input  logic            br_en,
  input  logic            pc_sel_reg,
  input  logic            opa_sel_reg,
  input  logic [1:0]      opb_sel,
  input  logic [2:0]      alu_op,
  input  logic            wr_sel_rd,
  input  logic            wb_sel_mem,
  input  logic            rf_we,
  input  logic            mem_we,
  output logic [5:0]      opcode,
  output logic [5:0]      funct,
  output logic            zero_flag,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] mem_wdata,
  output logic [XLEN-1:0] alu_y
);
  localparam int MAW = $clog2(MEM_WORDS);
  localparam int RAW = $clog2(NREGS);

  logic [XLEN-1:0] mem [MEM_WORDS];
  logic [XLEN-1:0] rf  [NREGS];

  logic [XLEN-1:0] ir_q, dr_q, a_q, b_q, aluout_q;
  logic [XLEN-1:0] opa, opb, imm_ext, pc_next, wb_data;
  logic [RAW-1:0]  rs_idx, rt_idx, wr_idx;
  logic [MAW-1:0]  word_idx;
  logic            pc_en;

  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];
  assign rs_idx    = ir_q[25:21];
  assign rt_idx    = ir_q[20:16];
  assign wr_idx    = wr_sel_rd ? ir_q[15:11] : ir_q[20:16];
  assign imm_ext   = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};

  assign mem_addr  = addr_sel_data ? aluout_q : pc;
  assign word_idx  = mem_addr[MAW+1:2];
  assign mem_rdata = mem[word_idx];
  assign mem_wdata = b_q;

  always_ff @(posedge clk)
    if (mem_we) mem[word_idx] <= b_q;

  assign opa = opa_sel_reg ? a_q : pc;

  always_comb begin
    case (opb_sel)
      2'b00:   opb = b_q;
      2'b01:   opb = XLEN'(4);
      2'b10:   opb = imm_ext;
      default: opb = {imm_ext[XLEN-3:0], 2'b00};
    endcase
  end

  always_comb begin
    case (alu_op)
      3'b010:  alu_y = opa + opb;
      3'b110:  alu_y = opa - opb;
      3'b000:  alu_y = opa & opb;
      3'b001:  alu_y = opa | opb;
      3'b111:  alu_y = {{(XLEN-1){1'b0}}, $signed(opa) < $signed(opb)};
      default: alu_y = '0;
    endcase
  end

  assign zero_flag = (alu_y == '0);
  assign pc_en     = pc_load | (br_en & zero_flag);
  assign pc_next   = pc_sel_reg ? aluout_q : alu_y;
  assign wb_data   = wb_sel_mem ? dr_q : aluout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      ir_q     <= '0;
      dr_q     <= '0;
      a_q      <= '0;
      b_q      <= '0;
      aluout_q <= '0;
    end else begin
      if (pc_en)   pc   <= pc_next;
      if (ir_load) ir_q <= mem_rdata;
      dr_q     <= mem_rdata;
      a_q      <= (rs_idx == '0) ? '0 : rf[rs_idx];
      b_q      <= (rt_idx == '0) ? '0 : rf[rt_idx];
      aluout_q <= alu_y;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
    end else if (rf_we) begin
      rf[wr_idx] <= wb_data;
    end
  end
endmodule

// File: rtl/shared_mem_datapath_checker.sv
module shared_mem_datapath_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ir_load,
  input logic            pc_load,
  input logic            br_en,
  input logic            pc_sel_reg,
  input logic            opa_sel_reg,
  input logic [1:0]      opb_sel,
  input logic [2:0]      alu_op,
  input logic            zero_flag,
  input logic [5:0]      opcode,
  input logic [5:0]      funct,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] alu_out
);
  AST_PC_RESET: assert property (@(posedge clk) $rose(rst_n) |-> pc == '0); // R1

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(opcode) && $stable(funct)); // R3

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_load && !br_en) |=> $stable(pc)); // R9

  AST_PC_STEP4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !pc_sel_reg && !opa_sel_reg && opb_sel == 2'b01 && alu_op == 3'b010)
    |=> pc == $past(pc) + XLEN'(4)); // R7

  AST_BRANCH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_load && br_en && zero_flag && pc_sel_reg) |=> pc == $past(alu_out)); // R9
endmodule

bind shared_mem_datapath shared_mem_datapath_checker #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .pc_load(pc_load), .br_en(br_en),
  .pc_sel_reg(pc_sel_reg), .opa_sel_reg(opa_sel_reg), .opb_sel(opb_sel),
  .alu_op(alu_op), .zero_flag(zero_flag), .opcode(opcode), .funct(funct),
  .pc(pc), .alu_out(aluout_q)
);

// File: tb/shared_mem_datapath_bench.sv
module shared_mem_datapath_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_sel_data, ir_load, pc_load, br_en, pc_sel_reg, opa_sel_reg;
  logic [1:0]  opb_sel;
  logic [2:0]  alu_op;
  logic        wr_sel_rd, wb_sel_mem, rf_we, mem_we;
  logic [5:0]  opcode, funct;
  logic        zero_flag;
  logic [31:0] pc, mem_addr, mem_rdata, mem_wdata, alu_y;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  shared_mem_datapath u_shared_mem_datapath (
    .clk(clk), .rst_n(rst_n), .addr_sel_data(addr_sel_data), .ir_load(ir_load),
    .pc_load(pc_load), .br_en(br_en), .pc_sel_reg(pc_sel_reg),
    .opa_sel_reg(opa_sel_reg), .opb_sel(opb_sel), .alu_op(alu_op),
    .wr_sel_rd(wr_sel_rd), .wb_sel_mem(wb_sel_mem), .rf_we(rf_we), .mem_we(mem_we),
    .opcode(opcode), .funct(funct), .zero_flag(zero_flag), .pc(pc),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .alu_y(alu_y)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic iord, irw, pcw, br, pcs, sa, input logic [1:0] sb,
                       input logic [2:0] op, input logic rd, m2r, rw, mw);
    addr_sel_data = iord; ir_load = irw; pc_load = pcw; br_en = br; pc_sel_reg = pcs;
    opa_sel_reg = sa; opb_sel = sb; alu_op = op; wr_sel_rd = rd; wb_sel_mem = m2r;
    rf_we = rw; mem_we = mw;
    #1;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic fetch(input logic [31:0] exp_pc);
    drive(0,1,1,0,0,0,2'b01,3'b010,0,0,0,0);
    chk("R2 fetch address", mem_addr, exp_pc);
    chk("R6 R7 pc+4", alu_y, exp_pc + 4);
    tick();
    chk("R9 pc after fetch", pc, exp_pc + 4);
  endtask

  task automatic decode(input logic [31:0] exp_tgt);
    drive(0,0,0,0,0,0,2'b11,3'b010,0,0,0,0);
    chk("R7 shifted immediate target", alu_y, exp_tgt);
    tick();
  endtask

  task automatic r_type(input logic [2:0] op, input logic [31:0] exp, input string req);
    drive(0,0,0,0,0,1,2'b00,op,0,0,0,0);
    chk(req, alu_y, exp);
    chk("R8 zero flag", {31'd0, zero_flag}, {31'd0, exp == 0});
    tick();
    drive(0,0,0,0,0,1,2'b00,op,1,0,1,0);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 pc reset", pc, 0);
    chk("R1 opcode reset", {26'd0, opcode}, 0);
    chk("R1 funct reset", {26'd0, funct}, 0);
  endtask

  task automatic t_load(input logic [31:0] pc0, input logic [31:0] addr, input logic [31:0] val);
    fetch(pc0);
    chk("R3 opcode after fetch", {26'd0, opcode}, 32'h23);
    decode(pc0 + 4 + (addr << 2));
    drive(0,0,0,0,0,1,2'b10,3'b010,0,0,0,0);
    chk("R7 sign-extended address", alu_y, addr);
    tick();
    drive(1,0,0,0,0,1,2'b10,3'b010,0,0,0,0);
    chk("R2 data address", mem_addr, addr);
    chk("R2 data read", mem_rdata, val);
    tick();
    chk("R3 ir held while data read", {26'd0, opcode}, 32'h23);
    drive(0,0,0,0,0,1,2'b10,3'b010,0,1,1,0);
    tick();
  endtask

  task automatic t_store();
    fetch(32'h0C);
    chk("R3 store opcode", {26'd0, opcode}, 32'h2B);
    decode(32'h10 + 32'h220);
    drive(0,0,0,0,0,1,2'b10,3'b010,0,0,0,0);
    chk("R5 R4 base is zero", alu_y, 32'h88);
    chk("R4 stored operand", mem_wdata, 8);
    tick();
    drive(1,0,0,0,0,1,2'b10,3'b010,0,0,0,1);
    chk("R10 store data", mem_wdata, 8);
    tick();
    drive(1,0,0,0,0,1,2'b10,3'b010,0,0,0,0);
    chk("R10 stored word reads back", mem_rdata, 8);
    tick();
  endtask

  task automatic t_branch(input logic [31:0] pc0, input logic [31:0] tgt,
                          input logic taken, input string req);
    fetch(pc0);
    decode(tgt);
    drive(0,0,0,1,1,1,2'b00,3'b110,0,0,0,0);
    chk({req, " zero flag"}, {31'd0, zero_flag}, {31'd0, taken});
    tick();
    chk({req, " pc"}, pc, taken ? tgt : pc0 + 4);
  endtask

  initial begin
    u_shared_mem_datapath.mem[0]  = 32'h8C01_0080;
    u_shared_mem_datapath.mem[1]  = 32'h8C02_0084;
    u_shared_mem_datapath.mem[2]  = 32'h0022_1820;
    u_shared_mem_datapath.mem[3]  = 32'hAC03_0088;
    u_shared_mem_datapath.mem[4]  = 32'h0022_2022;
    u_shared_mem_datapath.mem[5]  = 32'h0041_282A;
    u_shared_mem_datapath.mem[6]  = 32'h0022_3024;
    u_shared_mem_datapath.mem[7]  = 32'h0022_3825;
    u_shared_mem_datapath.mem[8]  = 32'h1022_0002;
    u_shared_mem_datapath.mem[9]  = 32'h1021_0003;
    u_shared_mem_datapath.mem[13] = 32'h0022_0020;
    u_shared_mem_datapath.mem[14] = 32'h0000_4025;
    u_shared_mem_datapath.mem[32] = 32'h0000_0005;
    u_shared_mem_datapath.mem[33] = 32'h0000_0003;
    u_shared_mem_datapath.mem[34] = 32'h0000_0000;
    drive(0,0,0,0,0,0,2'b00,3'b010,0,0,0,0);
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_load(32'h00, 32'h80, 5);
    t_load(32'h04, 32'h84, 3);
    fetch(32'h08);
    chk("R3 funct after fetch", {26'd0, funct}, 32'h20);
    decode(32'h0C + 32'h6080);
    r_type(3'b010, 8, "R8 add");
    t_store();
    fetch(32'h10); decode(32'h14 + 32'h8088); r_type(3'b110, 2, "R8 subtract");
    fetch(32'h14); decode(32'h18 + 32'hA0A8); r_type(3'b111, 1, "R8 set-less-than");
    fetch(32'h18); decode(32'h1C + 32'hC090); r_type(3'b000, 1, "R8 and");
    fetch(32'h1C); decode(32'h20 + 32'hE094); r_type(3'b001, 7, "R8 or");
    t_branch(32'h20, 32'h2C, 1'b0, "R9 branch not taken");
    t_branch(32'h24, 32'h34, 1'b1, "R9 branch taken");
    fetch(32'h34); decode(32'h38 + 32'h80); r_type(3'b010, 8, "R5 add into r0");
    fetch(32'h38); decode(32'h3C + 32'h10094);
    r_type(3'b001, 0, "R4 register 0 reads zero");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule